// File: doc/BRIEF.md
# UART Interrupt Priority Controller

This block gathers the interrupt conditions of one UART channel, masks each with its bit of an interrupt-enable register, and reports exactly one pending source, the one with the highest priority, through an interrupt-status byte. Receive-data-ready and receive-timeout sit on a shared level. Three flow-control sources rank below all the others: software flow control, then RTS and CTS changes. While a higher source is pending, a lower one does not appear in the status byte. It shows only once the higher source has gone.

Most sources are level flags that the surrounding channel logic drives and clears. The transmit-empty condition is held in the block. It is set at reset and on each rising edge of the holding-register-empty flag. It clears on a write to the holding register, or on a status read that returns the transmit code. The block drives one active-high interrupt line. The tri-state enable of that line comes either from a strap pin or from a modem-control bit. The serial shifters, the FIFOs and the baud generator sit outside the block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Reset loads the enable register with 0x02 (transmit-empty enabled only) and sets the transmit-empty latch. The first status update after reset therefore reports the transmit code 0x02.
- R2: Each source reaches the status and interrupt outputs only while its enable bit is 1. The enable bits are: bit0 receive data, bit1 transmit empty, bit2 line error, bit3 receive timeout, bit4 modem status, bit5 software flow control, bit6 RTS change, bit7 CTS change.
- R3: Priority from highest to lowest is: line error (code 3'b011), receive data/timeout (3'b010), transmit empty (3'b001), modem status (3'b000), software flow control (3'b100), RTS/CTS change (3'b101).
- R4: Receive-timeout reports the same code as receive-data. It is gated by enable bit 3 and is ignored while the receive FIFO count is zero.
- R5: The receive-data source is pending when the FIFO count is nonzero and greater than or equal to the trigger level.
- R6: Only the highest pending source is reported. A lower one becomes visible one cycle after the higher one drops. A status read while another source is reported leaves transmit-empty pending.
- R7: Transmit-empty clears on a holding-register write. It also clears on a status read in a cycle where the status output shows 0x02.
- R8: Transmit-empty is set again on a rising edge of the holding-register-empty flag.
- R9: The status output is 0x01 when no enabled source is pending. Otherwise it is {4'b0, code, 1'b0}.
- R10: The interrupt output is active high. It equals the OR of all enabled pending sources and is registered one cycle after its inputs.
- R11: The interrupt output enable is 1 while the strap pin is 1. While the strap is 0 it follows the stored modem-control bit. It updates one cycle after either changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intsel | input | 1 | Strap: 1 forces the interrupt output enabled |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| mcr_wr | input | 1 | Modem-control write strobe |
| mcr_oe_bit | input | 1 | Modem-control interrupt-enable bit write value |
| line_err | input | 1 | Line status error flag |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger level |
| rx_timeout | input | 1 | Receive timeout flag |
| thr_empty | input | 1 | Transmit holding register empty flag |
| modem_chg | input | 1 | Modem status change flag |
| xoff_det | input | 1 | Software flow-control character seen |
| rts_chg | input | 1 | RTS change flag |
| cts_chg | input | 1 | CTS change flag |
| isr_rd | input | 1 | Status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| isr_q | output | 8 | Interrupt status |
| irq_o | output | 1 | Interrupt request, active high |
| irq_oe | output | 1 | Tri-state enable for the interrupt output |

## Verification
The assertions assume that every input is synchronous to clk and held for whole cycles. They also assume that a transmit-empty rising edge never lands in the same cycle as a clearing read or write. The bench drives all inputs just after the falling edge. It never pulses thr_empty high together with thr_wr or a status read. Source flags stay as level inputs that the bench raises and drops, just as the channel logic would.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_LVL = 6;

  // enable register bit positions
  localparam int EN_RXD  = 0;
  localparam int EN_TXE  = 1;
  localparam int EN_LSR  = 2;
  localparam int EN_RTO  = 3;
  localparam int EN_MSR  = 4;
  localparam int EN_SWFC = 5;
  localparam int EN_RTS  = 6;
  localparam int EN_CTS  = 7;

  // level index 0 is the highest priority
  localparam int LV_LSR  = 0;
  localparam int LV_RX   = 1;
  localparam int LV_TX   = 2;
  localparam int LV_MSR  = 3;
  localparam int LV_SWFC = 4;
  localparam int LV_HWFC = 5;

  localparam logic [2:0] LVL_CODE [NUM_LVL] =
    '{3'b011, 3'b010, 3'b001, 3'b000, 3'b100, 3'b101};

  localparam logic [7:0] ISR_NONE   = 8'h01;
  localparam logic [7:0] IER_RESET  = 8'h02;
endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       intsel,
  input  logic       ier_wr,
  input  logic [7:0] ier_wdata,
  input  logic       mcr_wr,
  input  logic       mcr_oe_bit,
  output logic [7:0] ier_q,
  output logic       oe_q
);
  logic mcr_oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q    <= IER_RESET;
      mcr_oe_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      if (ier_wr) ier_q <= ier_wdata;
      if (mcr_wr) mcr_oe_q <= mcr_oe_bit;
      oe_q <= intsel | mcr_oe_q;
    end
  end

  // R11: strap high forces the enable on the next cycle
  assert_strap_forces_oe_R11: assert property (
    @(posedge clk) disable iff (rst) intsel |=> oe_q);

  // R1: enable register holds its reset value on the first cycle out of reset
  assert_ier_reset_R1: assert property (
    @(posedge clk) disable iff (rst) $past(rst) |-> (ier_q == IER_RESET));
endmodule

// File: rtl/uart_irq_txe_latch.sv
module uart_irq_txe_latch (
  input  logic clk,
  input  logic rst,
  input  logic thr_empty,
  input  logic thr_wr,
  input  logic read_clr,
  output logic txe_q
);
  logic empty_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      txe_q   <= 1'b1;
      empty_d <= 1'b1;
    end else begin
      empty_d <= thr_empty;
      if (thr_empty && !empty_d) txe_q <= 1'b1;
      if (read_clr || thr_wr)    txe_q <= 1'b0;
    end
  end

  // R1: transmit-empty pending right after reset
  assert_txe_after_reset_R1: assert property (
    @(posedge clk) disable iff (rst) $past(rst) |-> txe_q);

  // R7: a holding-register write clears the latch
  assert_thr_wr_clears_R7: assert property (
    @(posedge clk) disable iff (rst) thr_wr |=> !txe_q);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int LVLS = NUM_LVL
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LVLS-1:0] req,
  output logic [LVLS-1:0] grant,
  output logic [2:0]      code,
  output logic            any
);
  logic [LVLS:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < LVLS; g++) begin : g_chain
    assign grant[g]     = req[g] & ~blocked[g];
    assign blocked[g+1] = blocked[g] | req[g];
  end

  assign any = blocked[LVLS];

  always_comb begin
    code = 3'b000;
    for (int i = 0; i < LVLS; i++)
      if (grant[i]) code = code | LVL_CODE[i];
  end

  // R6: never more than one level reported
  assert_single_grant_R6: assert property (
    @(posedge clk) disable iff (rst) $onehot0(grant));

  // R3: the top pending request always wins
  assert_top_wins_R3: assert property (
    @(posedge clk) disable iff (rst) req[0] |-> grant[0]);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             intsel,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  input  logic             mcr_wr,
  input  logic             mcr_oe_bit,
  input  logic             line_err,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             rx_timeout,
  input  logic             thr_empty,
  input  logic             modem_chg,
  input  logic             xoff_det,
  input  logic             rts_chg,
  input  logic             cts_chg,
  input  logic             isr_rd,
  input  logic             thr_wr,
  output logic [7:0]       isr_q,
  output logic             irq_o,
  output logic             irq_oe
);
  localparam logic [3:0] TX_LOW = {LVL_CODE[LV_TX], 1'b0};

  logic [7:0]         ier_q;
  logic               txe_q;
  logic               read_clr;
  logic               fifo_nz;
  logic               rx_lvl_hit;
  logic [NUM_LVL-1:0] lvl;
  logic [NUM_LVL-1:0] grant;
  logic [2:0]         code;
  logic               any;

  uart_irq_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .intsel     (intsel),
    .ier_wr     (ier_wr),
    .ier_wdata  (ier_wdata),
    .mcr_wr     (mcr_wr),
    .mcr_oe_bit (mcr_oe_bit),
    .ier_q      (ier_q),
    .oe_q       (irq_oe)
  );

  assign read_clr = isr_rd && (isr_q[3:0] == TX_LOW);

  uart_irq_txe_latch u_txe (
    .clk       (clk),
    .rst       (rst),
    .thr_empty (thr_empty),
    .thr_wr    (thr_wr),
    .read_clr  (read_clr),
    .txe_q     (txe_q)
  );

  assign fifo_nz    = (rx_count != '0);
  assign rx_lvl_hit = fifo_nz && (rx_count >= rx_trig);

  always_comb begin
    lvl          = '0;
    lvl[LV_LSR]  = line_err & ier_q[EN_LSR];
    lvl[LV_RX]   = (rx_lvl_hit & ier_q[EN_RXD]) |
                   (rx_timeout & fifo_nz & ier_q[EN_RTO]);
    lvl[LV_TX]   = txe_q & ier_q[EN_TXE];
    lvl[LV_MSR]  = modem_chg & ier_q[EN_MSR];
    lvl[LV_SWFC] = xoff_det & ier_q[EN_SWFC];
    lvl[LV_HWFC] = (rts_chg & ier_q[EN_RTS]) | (cts_chg & ier_q[EN_CTS]);
  end

  uart_irq_prio #(.LVLS(NUM_LVL)) u_prio (
    .clk   (clk),
    .rst   (rst),
    .req   (lvl),
    .grant (grant),
    .code  (code),
    .any   (any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= ISR_NONE;
      irq_o <= 1'b0;
    end else begin
      isr_q <= any ? {4'b0000, code, 1'b0} : ISR_NONE;
      irq_o <= |lvl;
    end
  end

  // R9: status shows "none" exactly when the line is idle
  assert_none_matches_irq_R9: assert property (
    @(posedge clk) disable iff (rst) isr_q[0] == !irq_o);

  // R10: any enabled pending source raises the line next cycle
  assert_irq_follows_R10: assert property (
    @(posedge clk) disable iff (rst) (|lvl) |=> irq_o);

  // R4: timeout ignored with an empty FIFO
  assert_timeout_needs_data_R4: assert property (
    @(posedge clk) disable iff (rst)
      (!fifo_nz && !line_err && !txe_q && !modem_chg && !xoff_det &&
       !rts_chg && !cts_chg) |=> !irq_o);
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic intsel = 0, ier_wr = 0, mcr_wr = 0, mcr_oe_bit = 0;
  logic [7:0] ier_wdata = '0;
  logic line_err = 0, rx_timeout = 0, thr_empty = 1, modem_chg = 0;
  logic xoff_det = 0, rts_chg = 0, cts_chg = 0, isr_rd = 0, thr_wr = 0;
  logic [CNT_W-1:0] rx_count = '0, rx_trig = 5'd1;
  logic [7:0] isr_q;
  logic irq_o, irq_oe;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  uart_irq_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .intsel(intsel), .ier_wr(ier_wr),
    .ier_wdata(ier_wdata), .mcr_wr(mcr_wr), .mcr_oe_bit(mcr_oe_bit),
    .line_err(line_err), .rx_count(rx_count), .rx_trig(rx_trig),
    .rx_timeout(rx_timeout), .thr_empty(thr_empty), .modem_chg(modem_chg),
    .xoff_det(xoff_det), .rts_chg(rts_chg), .cts_chg(cts_chg),
    .isr_rd(isr_rd), .thr_wr(thr_wr), .isr_q(isr_q), .irq_o(irq_o),
    .irq_oe(irq_oe));

  // behavioural reference model
  logic [7:0] m_ier;
  logic m_mcr, m_tx, m_prev;
  logic [7:0] e_isr = 8'h01;
  logic e_irq = 0, e_oe = 0;

  always @(posedge clk) begin
    logic [7:0] n_isr;
    logic n_tx;
    if (rst) begin
      m_ier = 8'h02; m_mcr = 0; m_tx = 1; m_prev = 1;
      e_isr = 8'h01; e_irq = 0; e_oe = 0;
    end else begin
      n_isr = 8'h01;
      if (line_err && m_ier[2]) n_isr = 8'h06;
      else if ((rx_count != 0) && ((rx_count >= rx_trig && m_ier[0]) ||
               (rx_timeout && m_ier[3]))) n_isr = 8'h04;
      else if (m_tx && m_ier[1]) n_isr = 8'h02;
      else if (modem_chg && m_ier[4]) n_isr = 8'h00;
      else if (xoff_det && m_ier[5]) n_isr = 8'h08;
      else if ((rts_chg && m_ier[6]) || (cts_chg && m_ier[7])) n_isr = 8'h0A;
      n_tx = m_tx;
      if (thr_empty && !m_prev) n_tx = 1;
      if (thr_wr || (isr_rd && e_isr == 8'h02)) n_tx = 0;
      e_oe = intsel | m_mcr;
      e_irq = (n_isr != 8'h01);
      e_isr = n_isr;
      m_tx = n_tx;
      m_prev = thr_empty;
      if (ier_wr) m_ier = ier_wdata;
      if (mcr_wr) m_mcr = mcr_oe_bit;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks += 3;
      if (isr_q !== e_isr) begin
        fails++;
        $display("FAIL %s isr actual=%h expected=%h", cur_req, isr_q, e_isr);
      end
      if (irq_o !== e_irq) begin
        fails++;
        $display("FAIL %s irq actual=%b expected=%b", cur_req, irq_o, e_irq);
      end
      if (irq_oe !== e_oe) begin
        fails++;
        $display("FAIL %s oe actual=%b expected=%b", cur_req, irq_oe, e_oe);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wr = 1; ier_wdata = v; step(1); ier_wr = 0;
  endtask

  task automatic rd_isr();
    isr_rd = 1; step(1); isr_rd = 0;
  endtask

  initial begin
    step(3); rst = 0;
    cur_req = "R1"; step(3);            // transmit code right after reset
    cur_req = "R7"; rd_isr(); step(2);   // read while 0x02 clears
    cur_req = "R9"; step(3);             // idle reports 0x01
    cur_req = "R8"; thr_empty = 0; step(2); thr_empty = 1; step(3);
    cur_req = "R7"; thr_wr = 1; step(1); thr_wr = 0; step(2);
    cur_req = "R2"; wr_ier(8'h00);
    line_err = 1; rx_count = 5'd4; rx_timeout = 1; modem_chg = 1;
    xoff_det = 1; rts_chg = 1; cts_chg = 1; step(3);
    cur_req = "R3"; wr_ier(8'hFF); step(2);
    line_err = 0; step(2);
    rx_count = 0; rx_timeout = 0; step(2);
    modem_chg = 0; step(2);
    xoff_det = 0; step(2);
    rts_chg = 0; step(2);
    cur_req = "R10"; cts_chg = 0; step(2); cts_chg = 1; step(2); cts_chg = 0;
    cur_req = "R6"; thr_empty = 0; step(1); thr_empty = 1; step(1);
    line_err = 1; step(2); rd_isr(); step(1);
    line_err = 0; step(3);              // transmit still pending
    thr_wr = 1; step(1); thr_wr = 0; step(2);
    cur_req = "R4"; wr_ier(8'h08);
    rx_timeout = 1; rx_count = 0; step(3);
    rx_count = 5'd1; step(3);
    wr_ier(8'h00); step(2); rx_timeout = 0;
    cur_req = "R5"; wr_ier(8'h01); rx_trig = 5'd8;
    rx_count = 5'd7; step(2); rx_count = 5'd8; step(2);
    rx_count = 5'd12; step(2); rx_trig = 5'd0; rx_count = 0; step(2);
    cur_req = "R11"; intsel = 0;
    mcr_wr = 1; mcr_oe_bit = 1; step(1); mcr_wr = 0; step(3);
    mcr_wr = 1; mcr_oe_bit = 0; step(1); mcr_wr = 0; step(3);
    intsel = 1; step(3); intsel = 0; step(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule